// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block takes a floating-point result that upstream arithmetic has already normalised and widened with three extra low-order bits. The extra bits are guard, round and sticky, in that order below the last fraction bit. The stage reduces the result to a packed 32-bit single-precision word. Its inputs are a sign, a biased 8-bit exponent and a 24-bit significand whose top bit is the hidden one. A 2-bit mode picks one of four rounding directions. The stage decides whether to add one unit in the last place. If that increment carries out of the significand, it renormalises. If the exponent then reaches its all-ones code, it saturates to a signed infinity.

The stage also reports whether rounding lost information (inexact) and whether the result overflowed. The arithmetic is combinational. A parameter places an optional register on the result, so the stage can either close a pipeline stage or sit inside one. With the register in place, a valid strobe travels alongside the data. Subnormal results and the generation of the extra bits belong to other logic.

Top module: `fp_round_unit`

## Requirements
- R1: With mode 2'b00 (nearest, ties to even), the significand is incremented when the guard bit is 1 and either the round bit or the sticky bit is 1.
- R2: With mode 2'b00, an exact halfway case (guard/round/sticky = 3'b100) increments only when the significand's least significant bit is 1, so the result always ends in 0.
- R3: With mode 2'b00, a guard bit of 0 leaves the significand truncated.
- R4: With mode 2'b01 (toward zero), the sign, exponent and fraction pass through unchanged whatever the extra bits are.
- R5: With mode 2'b10 (toward plus infinity), the significand is incremented exactly when the sign is 0 and any extra bit is 1.
- R6: With mode 2'b11 (toward minus infinity), the significand is incremented exactly when the sign is 1 and any extra bit is 1.
- R7: An increment that carries out of the 24-bit significand yields a zero fraction and an exponent one higher than the input.
- R8: The inexact flag is 1 exactly when any of the three extra bits is 1. An input with all three at 0 appears unchanged in the output word.
- R9: When the rounded exponent reaches 255, the overflow flag is 1 and the word is an infinity (exponent 255, fraction 0) carrying the input sign.
- R10: With the output register enabled, results and out_valid appear one clock after in_valid is sampled high. An idle input cycle gives out_valid 0 one clock later. Reset clears out_valid and the word.
- R11: The output word packs the sign in bit 31, the exponent in bits 30:23 and the fraction (without the hidden bit) in bits 22:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand is present this cycle |
| in_sign | input | 1 | Sign of the value to round |
| in_exp | input | 8 | Biased exponent, 1 to 254 in normal use |
| in_sig | input | 24 | Significand, bit 23 is the hidden one |
| in_grs | input | 3 | Guard (bit 2), round (bit 1), sticky (bit 0) |
| in_mode | input | 2 | Rounding direction: 00 nearest even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity |
| out_valid | output | 1 | Result word is valid |
| out_word | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Rounding discarded nonzero bits |
| out_overflow | output | 1 | Result saturated to infinity |

## Verification
With the default register, every rounded word and both flags are due exactly one clock after the cycle in which in_valid is sampled. The driver pushes its expected item on the same falling edge where it presents the operand. The monitor pops one item only on a falling edge where out_valid is high, so a result that arrives late, early or without a matching operand breaks the queue order at once. Idle cycles placed between operands confirm that no result is emitted for them. A final drain confirms that no expected item is left unanswered.

// File: rtl/fprnd_pkg.sv
package fprnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rmode_e;

  // Decide whether one unit in the last place is added.
  function automatic logic want_increment(rmode_e mode, logic sgn, logic lsb,
                                          logic [2:0] grs);
    logic any_lost;
    any_lost = |grs;
    case (mode)
      RM_NEAR_EVEN: want_increment = grs[2] & (grs[1] | grs[0] | lsb);
      RM_TO_ZERO:   want_increment = 1'b0;
      RM_TO_POS:    want_increment = ~sgn & any_lost;
      default:      want_increment = sgn & any_lost;
    endcase
  endfunction

endpackage

// File: rtl/fprnd_decide.sv
module fprnd_decide
  import fprnd_pkg::*;
(
  input  logic       sign_i,
  input  logic       lsb_i,
  input  logic [2:0] grs_i,
  input  logic [1:0] mode_i,
  output logic       incr_o,
  output logic       inexact_o
);

  rmode_e mode_q;
  logic   tie_seen;

  assign mode_q    = rmode_e'(mode_i);
  assign incr_o    = want_increment(mode_q, sign_i, lsb_i, grs_i);
  assign inexact_o = |grs_i;
  assign tie_seen  = (grs_i == 3'b100);

  // R8: an increment is never taken on an exact input
  always_comb begin
    if (incr_o) begin
      assert_incr_needs_loss_R8: assert (inexact_o);
    end
  end

  // R2: a nearest-mode tie rounds to an even result
  always_comb begin
    if (tie_seen && mode_q == RM_NEAR_EVEN && incr_o) begin
      assert_tie_goes_even_R2: assert (lsb_i);
    end
  end

endmodule

// File: rtl/fprnd_adjust.sv
module fprnd_adjust #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W:0]   sig_i,
  input  logic              incr_i,
  output logic [EXP_W+FRAC_W:0] word_o,
  output logic              overflow_o
);

  localparam int SIG_W = FRAC_W + 1;

  logic [SIG_W:0]   sum;
  logic             carry_out;
  logic [SIG_W-1:0] sig_norm;
  logic [EXP_W:0]   exp_next;
  logic             exp_sat;

  assign sum       = {1'b0, sig_i} + {{SIG_W{1'b0}}, incr_i};
  assign carry_out = sum[SIG_W];
  assign sig_norm  = carry_out ? sum[SIG_W:1] : sum[SIG_W-1:0];
  assign exp_next  = {1'b0, exp_i} + {{EXP_W{1'b0}}, carry_out};
  assign exp_sat   = (exp_next >= {1'b0, {EXP_W{1'b1}}});

  always_comb begin
    if (exp_sat) begin
      word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      word_o = {sign_i, exp_next[EXP_W-1:0], sig_norm[FRAC_W-1:0]};
    end
  end
  assign overflow_o = exp_sat;

  // R7: a carry can only come from an all-ones significand being bumped
  always_comb begin
    if (carry_out) begin
      assert_carry_source_R7: assert (incr_i && (&sig_i));
    end
  end

endmodule

// File: rtl/fprnd_stage.sv
module fprnd_stage #(
  parameter int W       = 34,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_valid <= 1'b0;
          q       <= '0;
        end else begin
          q_valid <= d_valid;
          q       <= d;
        end
      end
    end else begin : g_comb
      assign q_valid = d_valid;
      assign q       = d;
    end
  endgenerate

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic [EXP_W-1:0]        in_exp,
  input  logic [FRAC_W:0]         in_sig,
  input  logic [2:0]              in_grs,
  input  logic [1:0]              in_mode,
  output logic                    out_valid,
  output logic [EXP_W+FRAC_W:0]   out_word,
  output logic                    out_inexact,
  output logic                    out_overflow
);

  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int STAGE_W = WORD_W + 2;

  logic              rnd_incr;
  logic              rnd_inexact;
  logic [WORD_W-1:0] adj_word;
  logic              adj_ovf;
  logic [STAGE_W-1:0] stage_q;

  fprnd_decide u_decide (
    .sign_i    (in_sign),
    .lsb_i     (in_sig[0]),
    .grs_i     (in_grs),
    .mode_i    (in_mode),
    .incr_o    (rnd_incr),
    .inexact_o (rnd_inexact)
  );

  fprnd_adjust #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_adjust (
    .sign_i     (in_sign),
    .exp_i      (in_exp),
    .sig_i      (in_sig),
    .incr_i     (rnd_incr),
    .word_o     (adj_word),
    .overflow_o (adj_ovf)
  );

  fprnd_stage #(.W(STAGE_W), .OUT_REG(OUT_REG)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d       ({adj_word, rnd_inexact, adj_ovf}),
    .q_valid (out_valid),
    .q       (stage_q)
  );

  assign out_word     = stage_q[STAGE_W-1:2];
  assign out_inexact  = stage_q[1];
  assign out_overflow = stage_q[0];

  // R9: overflow always comes with a signed infinity
  assert_ovf_is_inf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_overflow |-> (out_word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  generate
    if (OUT_REG) begin : g_chk
      assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      assert_inexact_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_inexact == ($past(in_grs) != 3'b000)));
      assert_trunc_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01 && in_exp != {EXP_W{1'b1}}) |=>
        (out_word == $past({in_sign, in_exp, in_sig[FRAC_W-1:0]})));
    end
  endgenerate

endmodule

// File: tb/fp_round_unit_tb_top.sv
`timescale 1ns/1ps
module fp_round_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [7:0]  in_exp = 8'd0;
  logic [23:0] in_sig = 24'd0;
  logic [2:0]  in_grs = 3'd0;
  logic [1:0]  in_mode = 2'd0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_inexact;
  logic        out_overflow;

  always #10 clk = ~clk;

  fp_round_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_grs(in_grs), .in_mode(in_mode),
    .out_valid(out_valid), .out_word(out_word), .out_inexact(out_inexact),
    .out_overflow(out_overflow)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        inx;
    logic        ovf;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Reference written from the requirements: rounding via half-ulp add
  function automatic exp_t model(input logic sg, input logic [7:0] e,
                                 input logic [22:0] f, input logic [2:0] grs,
                                 input logic [1:0] m);
    logic [23:0] sig;
    logic [27:0] wide;
    logic [24:0] r;
    int          en;
    exp_t        x;
    sig = {1'b1, f};
    case (m)
      2'b00: begin
        if (grs == 3'b100) r = {1'b0, sig} + {24'd0, sig[0]};
        else begin
          wide = {1'b0, sig, grs} + 28'd4;
          r = wide[27:3];
        end
      end
      2'b01: r = {1'b0, sig};
      2'b10: r = {1'b0, sig} + ((!sg && grs != 3'b000) ? 25'd1 : 25'd0);
      default: r = {1'b0, sig} + ((sg && grs != 3'b000) ? 25'd1 : 25'd0);
    endcase
    en = int'(e);
    if (r[24]) begin
      en = en + 1;
      r = r >> 1;
    end
    if (en >= 255) begin
      x.word = {sg, 8'hFF, 23'd0};
      x.ovf  = 1'b1;
    end else begin
      x.word = {sg, en[7:0], r[22:0]};
      x.ovf  = 1'b0;
    end
    x.inx = (grs != 3'b000);
    return x;
  endfunction

  task automatic send(input logic sg, input logic [7:0] e, input logic [22:0] f,
                      input logic [2:0] grs, input logic [1:0] m, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_sign  = sg;
    in_exp   = e;
    in_sig   = {1'b1, f};
    in_grs   = grs;
    in_mode  = m;
    exp_q.push_back(model(sg, e, f, grs, m));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per valid result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected result", out_word, 32'd0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word == e.word, t, "word", out_word, e.word);
          check(out_inexact == e.inx, t, "inexact", {31'd0, out_inexact}, {31'd0, e.inx});
          check(out_overflow == e.ovf, t, "overflow", {31'd0, out_overflow}, {31'd0, e.ovf});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "reset valid", {31'd0, out_valid}, 32'd0);
    check(out_word == 32'd0, "R10", "reset word", out_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R3: guard 0 truncates in nearest mode
    send(1'b0, 8'd130, 23'h2AAAA5, 3'b011, 2'b00, "R3 truncate below half");
    // R1: above half increments
    send(1'b0, 8'd130, 23'h2AAAA4, 3'b101, 2'b00, "R1 g and s");
    send(1'b1, 8'd100, 23'h000010, 3'b110, 2'b00, "R1 g and r");
    idle(2); // R10: bubble cycles produce nothing
    send(1'b0, 8'd77,  23'h7FFFFE, 3'b111, 2'b00, "R1 g r s");
    // R2: exact ties
    send(1'b0, 8'd140, 23'h123456, 3'b100, 2'b00, "R2 tie even stays");
    send(1'b1, 8'd140, 23'h123457, 3'b100, 2'b00, "R2 tie odd bumps");
    // R4: toward zero
    send(1'b0, 8'd90,  23'h7FFFFF, 3'b111, 2'b01, "R4 pos truncate");
    send(1'b1, 8'd90,  23'h0F0F0F, 3'b101, 2'b01, "R4 neg truncate");
    // R5: toward plus infinity
    send(1'b0, 8'd60,  23'h001000, 3'b001, 2'b10, "R5 pos sticky bumps");
    send(1'b1, 8'd60,  23'h001000, 3'b111, 2'b10, "R5 neg truncates");
    // R6: toward minus infinity
    send(1'b1, 8'd61,  23'h0000FF, 3'b001, 2'b11, "R6 neg sticky bumps");
    send(1'b0, 8'd61,  23'h0000FF, 3'b111, 2'b11, "R6 pos truncates");
    idle(1);
    // R8: exact inputs pass unchanged in every mode
    for (int m = 0; m < 4; m++) begin
      send(m[0], 8'd128, 23'h5A5A5A, 3'b000, m[1:0], "R8 exact");
    end
    // R7: carry renormalises (exponent -7 biased is 120)
    send(1'b0, 8'd120, 23'h7FFFFF, 3'b001, 2'b10, "R7 carry up");
    send(1'b1, 8'd120, 23'h7FFFFF, 3'b110, 2'b00, "R7 carry nearest");
    // R9: overflow to infinity
    send(1'b0, 8'd254, 23'h7FFFFF, 3'b100, 2'b00, "R9 pos overflow");
    send(1'b1, 8'd254, 23'h7FFFFF, 3'b010, 2'b11, "R9 neg overflow");
    send(1'b1, 8'd254, 23'h7FFFFF, 3'b111, 2'b10, "R9 no overflow when truncated");
    // R11: field placement with distinct pattern
    send(1'b1, 8'h81, 23'h400001, 3'b000, 2'b00, "R11 packing");
    idle(1);

    // Mixed sweep
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  e;
      logic [22:0] f;
      e = 8'd1 + 8'($urandom_range(253));
      f = 23'($urandom);
      if (i % 16 == 0) begin
        e = 8'd254;
        f = 23'h7FFFFF;
      end
      send(1'($urandom), e, f, 3'($urandom), 2'($urandom), "R1 R5 R6 R7 R9 sweep");
      if (i % 37 == 0) idle(1);
    end
    idle(4);
    check(exp_q.size() == 0, "R10", "drain", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule